// File: doc/BRIEF.md
# TLB Range Invalidation Controller

This block holds a small, fully associative translation cache and the engine that removes entries from it on command. Software programs a pair of page bounds, arms the invalidation through a two-bit select field, and then issues either a whole-cache flush or a range sweep through a command register. The flush empties every entry at once. The range sweep steps through the cache one entry per clock. It drops each entry whose virtual page number lies between the two bounds, with both bounds included, and it sets a completion flag when the sweep ends.

Software polls that flag and clears it by writing zero. The flush command is accepted at any time, even in the middle of a sweep. Software that gives up waiting for the flag can therefore always fall back to emptying the cache. A fill port loads entries and a lookup port translates a virtual page number. Both run alongside the sweep, so a lookup during a sweep already misses on entries the sweep has removed.

Top module: `tlb_inval_ctrl`

## Requirements
- R1: After reset every entry is invalid, and the select, start, end and done registers read zero. `walk_busy`, `lk_hit` and `lk_ppn` are low.
- R2: A fill sets the chosen entry valid with the given tag and physical page. A lookup answers on the next clock. `lk_hit` is high when a valid entry's tag equals `lk_vpn`, and the lowest-index match supplies `lk_ppn`. On a miss `lk_ppn` is zero.
- R3: Writing 0x2 to the command register (address 0) clears all valid bits at that clock edge. This holds even while a range sweep runs, and the sweep then carries on to its end.
- R4: The select register (address 1) keeps `reg_wdata[1:0]`. A command has no effect unless both bits are 1. Command values other than 0x1 and 0x2 have no effect.
- R5: The start register (address 2) and the end register (address 3) keep address bits [31:12] and read back with bits [11:0] zero.
- R6: Writing 0x1 to the command register raises `walk_busy` and starts a sweep that checks entry 0 through entry 15, one per clock. Each entry whose tag t satisfies start ≤ t ≤ end is invalidated. When start > end, nothing is removed.
- R7: The done flag (address 4, bit 0, also on `inval_done`) is set on the 16th clock edge after the edge that accepted the range command. `walk_busy` falls on that same edge.
- R8: Writing zero to address 4 clears the done flag, and a non-zero write leaves it unchanged. When the sweep completes on the same edge as a clearing write, the flag is set.
- R9: A range command written while a sweep runs is ignored. The sweep uses the bounds captured when it started, so writes to start or end during the sweep do not alter it.
- R10: A lookup during a sweep misses on any entry the sweep has already removed. A fill to an entry on the same edge as a flush or a sweep removal leaves that entry valid with the new contents.
- R11: `reg_rdata` shows, one clock later, the register selected by `reg_addr` as it stood before that edge. The command address and addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| fill_en | input | 1 | Load an entry |
| fill_idx | input | 4 | Entry to load |
| fill_vpn | input | 20 | Virtual page tag to load |
| fill_ppn | input | 20 | Physical page to load |
| lk_en | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page to translate |
| lk_hit | output | 1 | Lookup hit, one clock after the request |
| lk_ppn | output | 20 | Translated physical page, zero on miss |
| inval_done | output | 1 | Range sweep completion flag |
| walk_busy | output | 1 | Range sweep in progress |

## Verification
The properties assume that `fill_idx` always names an existing entry and that every input holds a known value from the first edge after reset. They also rely on a flush, sweep removal or fill landing on the edge where its request is sampled. The bench drives all inputs on the falling edge, keeps fill indices within the sixteen entries, and never leaves an input undriven. Its reference model steps the same edge ordering (removal, then flush, then fill), so same-edge collisions of fills with sweeps and flushes fall inside what the properties expect.

// File: rtl/tlbi_pkg.sv
package tlbi_pkg;
  localparam logic [2:0] A_CMD   = 3'd0;
  localparam logic [2:0] A_SEL   = 3'd1;
  localparam logic [2:0] A_START = 3'd2;
  localparam logic [2:0] A_END   = 3'd3;
  localparam logic [2:0] A_DONE  = 3'd4;

  localparam int unsigned CMD_RANGE = 32'h1;
  localparam int unsigned CMD_ALL   = 32'h2;
  localparam logic [1:0]  SEL_BOTH  = 2'b11;
endpackage

// File: rtl/tlbi_regs.sv
module tlbi_regs
  import tlbi_pkg::*;
#(
  parameter int DW = 32,
  parameter int PAGE_SHIFT = 12,
  localparam int VPN_W = DW - PAGE_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  input  logic             walk_busy_i,
  input  logic             walk_fin_i,
  output logic [VPN_W-1:0] start_vpn_o,
  output logic [VPN_W-1:0] end_vpn_o,
  output logic             flush_o,
  output logic             range_go_o,
  output logic             done_o,
  output logic [DW-1:0]    rd_data_o
);
  logic [1:0]       sel_q;
  logic [VPN_W-1:0] start_q, end_q;
  logic             done_q;
  logic [DW-1:0]    rd_q, rd_d;
  logic             cmd_wr, armed, done_clr;

  always_comb begin
    cmd_wr     = reg_we && (reg_addr == A_CMD);
    armed      = (sel_q == SEL_BOTH);
    flush_o    = cmd_wr && armed && (reg_wdata == DW'(CMD_ALL));
    range_go_o = cmd_wr && armed && (reg_wdata == DW'(CMD_RANGE)) && !walk_busy_i;
    done_clr   = reg_we && (reg_addr == A_DONE) && (reg_wdata == '0);
  end

  always_comb begin
    rd_d = '0;
    case (reg_addr)
      A_SEL:   rd_d = {{(DW-2){1'b0}}, sel_q};
      A_START: rd_d = {start_q, {PAGE_SHIFT{1'b0}}};
      A_END:   rd_d = {end_q, {PAGE_SHIFT{1'b0}}};
      A_DONE:  rd_d = {{(DW-1){1'b0}}, done_q};
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      start_q <= '0;
      end_q   <= '0;
      done_q  <= 1'b0;
      rd_q    <= '0;
    end else begin
      rd_q <= rd_d;
      if (reg_we) begin
        case (reg_addr)
          A_SEL:   sel_q   <= reg_wdata[1:0];
          A_START: start_q <= reg_wdata[DW-1:PAGE_SHIFT];
          A_END:   end_q   <= reg_wdata[DW-1:PAGE_SHIFT];
          default: ;
        endcase
      end
      if (walk_fin_i)    done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
    end
  end

  assign start_vpn_o = start_q;
  assign end_vpn_o   = end_q;
  assign done_o      = done_q;
  assign rd_data_o   = rd_q;

  // R7
  done_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(walk_fin_i));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && reg_we && reg_addr == A_DONE && reg_wdata != '0) |=> done_q);
endmodule

// File: rtl/tlbi_walker.sv
module tlbi_walker #(
  parameter int ENTRIES = 16,
  parameter int VPN_W = 20,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             range_go_i,
  input  logic [VPN_W-1:0] lo_i,
  input  logic [VPN_W-1:0] hi_i,
  input  logic [VPN_W-1:0] probe_vpn_i,
  output logic [IDX_W-1:0] probe_idx_o,
  output logic             clr_en_o,
  output logic             fin_o,
  output logic             busy_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [VPN_W-1:0] lo_q, hi_q;
  logic             at_last;

  always_comb begin
    at_last  = (idx_q == LAST);
    clr_en_o = busy_q && (probe_vpn_i >= lo_q) && (probe_vpn_i <= hi_q);
    fin_o    = busy_q && at_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (range_go_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      lo_q   <= lo_i;
      hi_q   <= hi_i;
    end else if (busy_q) begin
      idx_q <= idx_q + IDX_W'(1);
      if (at_last) busy_q <= 1'b0;
    end
  end

  assign probe_idx_o = idx_q;
  assign busy_o      = busy_q;

  // R6
  walk_start_chk: assert property (@(posedge clk) disable iff (rst)
    range_go_i |=> (busy_q && idx_q == '0));

  // R6
  walk_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !at_last) |=> (busy_q && idx_q == $past(idx_q) + IDX_W'(1)));

  // R7
  walk_end_chk: assert property (@(posedge clk) disable iff (rst)
    fin_o |=> !busy_q);
endmodule

// File: rtl/tlbi_store.sv
module tlbi_store #(
  parameter int ENTRIES = 16,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_en_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             flush_i,
  input  logic             clr_en_i,
  input  logic [IDX_W-1:0] probe_idx_i,
  output logic [VPN_W-1:0] probe_vpn_o,
  input  logic             lk_en_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             lk_hit_o,
  output logic [PPN_W-1:0] lk_ppn_o
);
  logic [ENTRIES-1:0] valid_q, valid_d, hit_vec;
  logic [VPN_W-1:0]   tag_q   [ENTRIES];
  logic [PPN_W-1:0]   ppn_mem [ENTRIES];
  logic [PPN_W-1:0]   ppn_rd_q;
  logic [IDX_W-1:0]   hit_idx;
  logic               hit_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hit_vec[e] = valid_q[e] && (tag_q[e] == lk_vpn_i);
  end

  always_comb begin
    hit_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--)
      if (hit_vec[e]) hit_idx = IDX_W'(e);
  end

  always_comb begin
    valid_d = valid_q;
    for (int e = 0; e < ENTRIES; e++) begin
      if (fill_en_i && fill_idx_i == IDX_W'(e))
        valid_d[e] = 1'b1;
      else if (flush_i || (clr_en_i && probe_idx_i == IDX_W'(e)))
        valid_d[e] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      hit_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      hit_q   <= lk_en_i && (|hit_vec);
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en_i) tag_q[fill_idx_i] <= fill_vpn_i;
  end

  always_ff @(posedge clk) begin
    if (fill_en_i) ppn_mem[fill_idx_i] <= fill_ppn_i;
    if (lk_en_i)   ppn_rd_q <= ppn_mem[hit_idx];
  end

  assign probe_vpn_o = tag_q[probe_idx_i];
  assign lk_hit_o    = hit_q;
  assign lk_ppn_o    = hit_q ? ppn_rd_q : '0;

  // R2
  fill_valid_chk: assert property (@(posedge clk) disable iff (rst)
    fill_en_i |=> valid_q[$past(fill_idx_i)]);

  // R3
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (flush_i && !fill_en_i) |=> (valid_q == '0));

  // R10
  sweep_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_en_i && !(fill_en_i && fill_idx_i == probe_idx_i)) |=> !valid_q[$past(probe_idx_i)]);
endmodule

// File: rtl/tlb_inval_ctrl.sv
module tlb_inval_ctrl #(
  parameter int ENTRIES = 16,
  parameter int VA_W = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int PPN_W = 20,
  localparam int VPN_W = VA_W - PAGE_SHIFT,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [VA_W-1:0]  reg_wdata,
  output logic [VA_W-1:0]  reg_rdata,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             lk_en,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             inval_done,
  output logic             walk_busy
);
  logic [VPN_W-1:0] start_vpn, end_vpn, probe_vpn;
  logic [IDX_W-1:0] probe_idx;
  logic             flush, range_go, clr_en, fin, busy;

  tlbi_regs #(.DW(VA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .walk_busy_i(busy), .walk_fin_i(fin),
    .start_vpn_o(start_vpn), .end_vpn_o(end_vpn), .flush_o(flush),
    .range_go_o(range_go), .done_o(inval_done), .rd_data_o(reg_rdata)
  );

  tlbi_walker #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_walker (
    .clk(clk), .rst(rst), .range_go_i(range_go), .lo_i(start_vpn),
    .hi_i(end_vpn), .probe_vpn_i(probe_vpn), .probe_idx_o(probe_idx),
    .clr_en_o(clr_en), .fin_o(fin), .busy_o(busy)
  );

  tlbi_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
    .clk(clk), .rst(rst), .fill_en_i(fill_en), .fill_idx_i(fill_idx),
    .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn), .flush_i(flush),
    .clr_en_i(clr_en), .probe_idx_i(probe_idx), .probe_vpn_o(probe_vpn),
    .lk_en_i(lk_en), .lk_vpn_i(lk_vpn), .lk_hit_o(lk_hit), .lk_ppn_o(lk_ppn)
  );

  assign walk_busy = busy;
endmodule

// File: tb/test_tlb_inval_ctrl.sv
`timescale 1ns/1ps
module test_tlb_inval_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        we;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        fill_en;
  logic [3:0]  fidx;
  logic [19:0] fvpn, fppn;
  logic        lk_en;
  logic [19:0] lkv;
  logic        hit;
  logic [19:0] ppn;
  logic        done, busy;

  always #2 clk = ~clk;

  tlb_inval_ctrl i_tlb_inval_ctrl (
    .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .fill_en(fill_en), .fill_idx(fidx), .fill_vpn(fvpn),
    .fill_ppn(fppn), .lk_en(lk_en), .lk_vpn(lkv), .lk_hit(hit), .lk_ppn(ppn),
    .inval_done(done), .walk_busy(busy)
  );

  // behavioural reference state
  bit  mv [16];
  int  mt [16];
  int  mp [16];
  int  m_sel, m_st, m_en, m_done, m_busy, m_idx, m_lo, m_hi;
  int  e_hit, e_ppn, e_rd, e_done, e_busy;
  int  n_chk = 0, n_bad = 0;
  bit  finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(hit === e_hit[0], "R2", "lk_hit", {31'b0, hit}, e_hit);
    chk(ppn === e_ppn[19:0], "R2", "lk_ppn", {12'b0, ppn}, e_ppn);
    chk(busy === e_busy[0], "R6", "walk_busy", {31'b0, busy}, e_busy);
    chk(done === e_done[0], "R7", "inval_done", {31'b0, done}, e_done);
    chk(rdata === e_rd, "R11", "reg_rdata", rdata, e_rd);
  endtask

  task automatic model_step();
    int h;
    bit fl, rg, fin;
    h = -1;
    for (int i = 15; i >= 0; i--) if (mv[i] && mt[i] == int'(lkv)) h = i;
    e_hit = (lk_en && h >= 0) ? 1 : 0;
    e_ppn = e_hit ? mp[h] : 0;
    case (addr)
      3'd1: e_rd = m_sel;
      3'd2: e_rd = m_st << 12;
      3'd3: e_rd = m_en << 12;
      3'd4: e_rd = m_done;
      default: e_rd = 0;
    endcase
    fl = we && addr == 3'd0 && wdata == 32'h2 && m_sel == 3;
    rg = we && addr == 3'd0 && wdata == 32'h1 && m_sel == 3 && m_busy == 0;
    fin = 0;
    if (m_busy != 0) begin
      if (mt[m_idx] >= m_lo && mt[m_idx] <= m_hi) mv[m_idx] = 0;
      if (m_idx == 15) begin fin = 1; m_busy = 0; end
      m_idx++;
    end
    if (fl) for (int i = 0; i < 16; i++) mv[i] = 0;
    if (fill_en) begin mv[fidx] = 1; mt[fidx] = int'(fvpn); mp[fidx] = int'(fppn); end
    if (rg) begin m_busy = 1; m_idx = 0; m_lo = m_st; m_hi = m_en; end
    if (we) begin
      if (addr == 3'd1) m_sel = int'(wdata[1:0]);
      if (addr == 3'd2) m_st = int'(wdata[31:12]);
      if (addr == 3'd3) m_en = int'(wdata[31:12]);
    end
    if (fin) m_done = 1;
    else if (we && addr == 3'd4 && wdata == 0) m_done = 0;
    e_done = m_done;
    e_busy = m_busy;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    we = 0; addr = 0; wdata = 0; fill_en = 0; fidx = 0; fvpn = 0; fppn = 0;
    lk_en = 0; lkv = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1; addr = a; wdata = d; cyc();
  endtask
  task automatic rd(input logic [2:0] a);
    addr = a; cyc();
  endtask
  task automatic fill(input int i, input int v, input int p);
    fill_en = 1; fidx = 4'(i); fvpn = 20'(v); fppn = 20'(p); cyc();
  endtask
  task automatic look(input int v);
    lk_en = 1; lkv = 20'(v); cyc();
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask
  task automatic fill_all();
    for (int i = 0; i < 16; i++) fill(i, 'h100 + i, 'h5000 + i);
  endtask
  task automatic look_all();
    for (int v = 'hFF; v <= 'h110; v++) look(v);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst = 1; we = 0; addr = 0; wdata = 0; fill_en = 0; fidx = 0; fvpn = 0;
    fppn = 0; lk_en = 0; lkv = 0;
    for (int i = 0; i < 16; i++) begin mv[i] = 0; mt[i] = 0; mp[i] = 0; end
    m_sel = 0; m_st = 0; m_en = 0; m_done = 0; m_busy = 0; m_idx = 0; m_lo = 0; m_hi = 0;
    e_hit = 0; e_ppn = 0; e_rd = 0; e_done = 0; e_busy = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare();                       // R1 reset state
    rst = 0;
    for (int a = 0; a < 8; a++) rd(3'(a));   // R1 / R11 all registers read zero
    look('h100);                     // R1 empty cache misses

    // R2 fills, lookups, lowest-index priority, miss gives zero
    fill_all();
    look_all();
    fill(3, 'h105, 'h7777);
    look('h105);
    look('h999);

    // R5 page masking on start/end
    wr(3'd2, 32'h00103ABC);
    wr(3'd3, 32'h00106FFF);
    rd(3'd2); rd(3'd3);

    // R4 commands without both select bits, and bad command values
    wr(3'd1, 32'h1); wr(3'd0, 32'h2); look_all();
    wr(3'd1, 32'h2); wr(3'd0, 32'h1); rd(3'd4);
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1);
    wr(3'd0, 32'h3); wr(3'd0, 32'h0); look_all();

    // R6 inclusive range sweep, R10 lookups during sweep, R9 ignored commands
    fill_all();
    wr(3'd0, 32'h1);
    for (int k = 0; k < 4; k++) look('h103 + k);
    wr(3'd0, 32'h1);                 // R9 range command while busy
    wr(3'd2, 32'h00100000);          // R9 bound write during sweep
    fill(9, 'h104, 'h4444);          // R10 fill ahead of the sweep gets removed
    look('h105);
    idle(8);
    rd(3'd4);                        // R7 done visible
    look_all();
    wr(3'd4, 32'h5); rd(3'd4);       // R8 non-zero write ignored
    wr(3'd4, 32'h0); rd(3'd4);       // R8 clear

    // R8 completion on the same edge as a clear
    wr(3'd2, 32'h00100000);
    wr(3'd0, 32'h1);
    idle(15);
    wr(3'd4, 32'h0);
    rd(3'd4);
    wr(3'd4, 32'h0);

    // R10 fill on the entry being swept that same edge
    fill_all();
    wr(3'd2, 32'h00100000); wr(3'd3, 32'h0010FFFF);
    wr(3'd0, 32'h1);
    idle(4);
    fill(4, 'h104, 'h6464);
    idle(12);
    look('h104);
    wr(3'd4, 32'h0);

    // R3 flush during a sweep, with a fill on the flush edge
    fill_all();
    wr(3'd2, 32'h00200000);
    wr(3'd0, 32'h1);
    idle(3);
    fill_en = 1; fidx = 4'd2; fvpn = 20'h333; fppn = 20'h3333;
    wr(3'd0, 32'h2);
    look('h333); look('h101);
    idle(14);
    rd(3'd4);

    // R6 start above end removes nothing
    fill_all();
    wr(3'd4, 32'h0);
    wr(3'd2, 32'h00200000); wr(3'd3, 32'h00100000);
    wr(3'd0, 32'h1);
    idle(17);
    look_all();

    // mixed traffic against the reference model
    for (int k = 0; k < 400; k++) begin
      int r;
      r = int'($urandom % 16);
      lk_en = 1; lkv = 20'('h100 + ($urandom % 18));
      if (r < 5) begin
        fill_en = 1; fidx = 4'($urandom % 16);
        fvpn = 20'('h100 + ($urandom % 18)); fppn = 20'($urandom);
      end
      if (r == 5) begin we = 1; addr = 3'd0; wdata = 32'h1; end
      else if (r == 6) begin we = 1; addr = 3'd0; wdata = (($urandom % 8) == 0) ? 32'h2 : 32'h1; end
      else if (r == 7) begin we = 1; addr = 3'd2; wdata = 32'(('h100 + ($urandom % 18)) << 12); end
      else if (r == 8) begin we = 1; addr = 3'd3; wdata = 32'(('h100 + ($urandom % 18)) << 12); end
      else if (r == 9) begin we = 1; addr = 3'd4; wdata = 32'($urandom % 2); end
      else if (r == 10) begin we = 1; addr = 3'd1; wdata = (($urandom % 4) == 0) ? 32'h1 : 32'h3; end
      else addr = 3'($urandom % 8);
      cyc();
    end
    idle(20);
    summary();
  end
endmodule